// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces horizontal and vertical scan timing for a small raster display. A pixel counter steps once for each pixel-clock enable. A line counter steps once per completed line. From these two counts the block decodes the visible area, the porches and the sync pulses. It drives two active-low sync outputs and a display-enable output, and it exposes the current counts so that a downstream pixel source can address its storage.

Everything runs on one clock. The pixel rate comes from a clock-enable input, which is nominally 10 MHz, and no derived clock is used. Each sync output and each visible-area flag is a set/reset flag. A flag is set one count before its region begins and cleared one count before the region ends. As a result every output changes on the same clock edge as the counts it describes. The default geometry is a 200-pixel by 600-line visible area inside a 264-pixel by 628-line total. Horizontal sync spans pixels 210 to 241 and vertical sync spans lines 601 to 604. All boundaries are parameters.

Top module: `vid_raster_timer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a clock edge, the block drives `hCount`=0, `vCount`=0, `hSyncN`=1, `vSyncN`=1 and `displayEnable`=1 after that edge, and `frameEnd` stays 0 while reset is high.
- R2: At each clock edge with `pixEn`=1, `hCount` increases by one unless it is at its last value, 263.
- R3: At a clock edge with `pixEn`=0, none of `hCount`, `vCount`, `hSyncN`, `vSyncN` or `displayEnable` changes.
- R4: `hCount` never exceeds 263. An enabled edge at 263 returns it to 0, so a line lasts 264 enabled cycles.
- R5: `vCount` changes only on an enabled edge where `hCount` is 263. On that edge it increases by one, or returns from 627 to 0, so a frame lasts 628 lines.
- R6: `hSyncN` is 0 exactly when `hCount` is 210 to 241 inclusive, and is 1 otherwise, aligned to the same edge as `hCount`.
- R7: `vSyncN` is 0 exactly when `vCount` is 601 to 604 inclusive, and is 1 otherwise, aligned to the same edge as `vCount`.
- R8: `displayEnable` is 1 exactly when `hCount` < 200 and `vCount` < 600.
- R9: `frameEnd` is 1 exactly in a cycle where `pixEn`=1, `hCount`=263 and `vCount`=627. This is the cycle whose edge wraps both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel clock enable, one pixel per high cycle |
| hCount | output | 9 | Current pixel position in the line |
| vCount | output | 10 | Current line position in the frame |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| displayEnable | output | 1 | High inside the visible area |
| frameEnd | output | 1 | High for the enabled cycle on the last pixel of a frame |

## Verification
Random gated enables with a roughly even duty separate true stepping from holding. This shows whether any counter or flag moves on a disabled cycle. A mid-run reset checks that the counters and flags are restored at once.

A continuous enable over a full frame and past its wrap walks every horizontal and vertical boundary. It exposes off-by-one placement of the sync and visible windows, as well as wrong terminal counts. At the last pixel of the frame, the enable is withheld for a few cycles. This shows whether the end-of-frame pulse follows the enable or just the counts.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  // Strobes from the decode logic to the register datapath.
  typedef struct packed {
    logic hStep;     // pixel counter advances
    logic hWrap;     // pixel counter returns to zero, line ends
    logic vWrap;     // line counter returns to zero, frame ends
    logic hSyncSet;  // next pixel enters horizontal sync
    logic hSyncClr;  // next pixel leaves horizontal sync
    logic vSyncSet;  // next line enters vertical sync
    logic vSyncClr;  // next line leaves vertical sync
    logic hActClr;   // next pixel leaves visible area
    logic vActClr;   // next line leaves visible area
  } vrtStrobes_t;

endpackage

// File: rtl/vrt_axis_ctr.sv
module vrt_axis_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wrap,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + W'(1);
  end

endmodule

// File: rtl/vrt_sr_flag.sv
module vrt_sr_flag #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= INIT;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/vrt_ctrl.sv
module vrt_ctrl
  import vrt_pkg::*;
#(
  parameter int H_ACTIVE     = 200,
  parameter int H_SYNC_START = 210,
  parameter int H_SYNC_END   = 242,
  parameter int H_TOTAL      = 264,
  parameter int V_ACTIVE     = 600,
  parameter int V_SYNC_START = 601,
  parameter int V_SYNC_END   = 605,
  parameter int V_TOTAL      = 628,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          pixEn,
  input  logic [HW-1:0] hCount,
  input  logic [VW-1:0] vCount,
  output vrtStrobes_t   strb
);

  // Every decode looks one count ahead, so registered flags line up with the counts.
  localparam logic [HW-1:0] H_LAST     = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT_LAST = HW'(H_ACTIVE - 1);
  localparam logic [HW-1:0] H_PRE_SYNC = HW'(H_SYNC_START - 1);
  localparam logic [HW-1:0] H_PRE_END  = HW'(H_SYNC_END - 1);
  localparam logic [VW-1:0] V_LAST     = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT_LAST = VW'(V_ACTIVE - 1);
  localparam logic [VW-1:0] V_PRE_SYNC = VW'(V_SYNC_START - 1);
  localparam logic [VW-1:0] V_PRE_END  = VW'(V_SYNC_END - 1);

  logic lineEnd;

  always_comb begin
    lineEnd       = pixEn && (hCount == H_LAST);
    strb.hStep    = pixEn;
    strb.hWrap    = lineEnd;
    strb.vWrap    = lineEnd && (vCount == V_LAST);
    strb.hSyncSet = pixEn && (hCount == H_PRE_SYNC);
    strb.hSyncClr = pixEn && (hCount == H_PRE_END);
    strb.hActClr  = pixEn && (hCount == H_ACT_LAST);
    strb.vSyncSet = lineEnd && (vCount == V_PRE_SYNC);
    strb.vSyncClr = lineEnd && (vCount == V_PRE_END);
    strb.vActClr  = lineEnd && (vCount == V_ACT_LAST);
  end

endmodule

// File: rtl/vrt_datapath.sv
module vrt_datapath
  import vrt_pkg::*;
#(
  parameter int H_TOTAL = 264,
  parameter int V_TOTAL = 628,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int NFLAG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  vrtStrobes_t   strb,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          displayEnable
);

  // Flag order: 0 hSync, 1 vSync, 2 hActive, 3 vActive
  localparam logic [NFLAG-1:0] FLAG_INIT = 4'b1100;

  logic [NFLAG-1:0] flagSet;
  logic [NFLAG-1:0] flagClr;
  logic [NFLAG-1:0] flagQ;

  assign flagSet = {strb.vWrap,   strb.hWrap,   strb.vSyncSet, strb.hSyncSet};
  assign flagClr = {strb.vActClr, strb.hActClr, strb.vSyncClr, strb.hSyncClr};

  vrt_axis_ctr #(.W(HW)) u_hCtr (
    .clk (clk),
    .rst (rst),
    .step(strb.hStep),
    .wrap(strb.hWrap),
    .cnt (hCount)
  );

  vrt_axis_ctr #(.W(VW)) u_vCtr (
    .clk (clk),
    .rst (rst),
    .step(strb.hWrap),
    .wrap(strb.vWrap),
    .cnt (vCount)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    vrt_sr_flag #(.INIT(FLAG_INIT[i])) u_flag (
      .clk(clk),
      .rst(rst),
      .set(flagSet[i]),
      .clr(flagClr[i]),
      .q  (flagQ[i])
    );
  end

  assign hSyncN        = ~flagQ[0];
  assign vSyncN        = ~flagQ[1];
  assign displayEnable = flagQ[2] & flagQ[3];

endmodule

// File: rtl/vid_raster_timer.sv
module vid_raster_timer
  import vrt_pkg::*;
#(
  parameter int H_ACTIVE     = 200,
  parameter int H_SYNC_START = 210,
  parameter int H_SYNC_END   = 242,
  parameter int H_TOTAL      = 264,
  parameter int V_ACTIVE     = 600,
  parameter int V_SYNC_START = 601,
  parameter int V_SYNC_END   = 605,
  parameter int V_TOTAL      = 628,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixEn,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          displayEnable,
  output logic          frameEnd
);

  vrtStrobes_t strb;

  vrt_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(V_ACTIVE), .V_SYNC_START(V_SYNC_START), .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL)
  ) u_ctrl (
    .pixEn (pixEn),
    .hCount(hCount),
    .vCount(vCount),
    .strb  (strb)
  );

  vrt_datapath #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .hCount       (hCount),
    .vCount       (vCount),
    .hSyncN       (hSyncN),
    .vSyncN       (vSyncN),
    .displayEnable(displayEnable)
  );

  assign frameEnd = strb.vWrap & ~rst;

endmodule

// File: rtl/vrt_checker.sv
module vrt_checker #(
  parameter int H_ACTIVE     = 200,
  parameter int H_SYNC_START = 210,
  parameter int H_SYNC_END   = 242,
  parameter int H_TOTAL      = 264,
  parameter int V_ACTIVE     = 600,
  parameter int V_SYNC_START = 601,
  parameter int V_SYNC_END   = 605,
  parameter int V_TOTAL      = 628,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst,
  input logic          pixEn,
  input logic [HW-1:0] hCount,
  input logic [VW-1:0] vCount,
  input logic          hSyncN,
  input logic          vSyncN,
  input logic          displayEnable,
  input logic          frameEnd
);

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pixEn && int'(hCount) != H_TOTAL - 1) |=> int'(hCount) == int'($past(hCount)) + 1);

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> ($stable(hCount) && $stable(vCount) && $stable(hSyncN)
               && $stable(vSyncN) && $stable(displayEnable)));

  // R4
  h_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(hCount) < H_TOTAL);

  // R4
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pixEn && int'(hCount) == H_TOTAL - 1) |=> hCount == '0);

  // R5
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(pixEn && int'(hCount) == H_TOTAL - 1) |=> $stable(vCount));

  // R6
  h_sync_win_chk: assert property (@(posedge clk) disable iff (rst)
    hSyncN == !(int'(hCount) >= H_SYNC_START && int'(hCount) < H_SYNC_END));

  // R7
  v_sync_win_chk: assert property (@(posedge clk) disable iff (rst)
    vSyncN == !(int'(vCount) >= V_SYNC_START && int'(vCount) < V_SYNC_END));

  // R8
  den_win_chk: assert property (@(posedge clk) disable iff (rst)
    displayEnable == (int'(hCount) < H_ACTIVE && int'(vCount) < V_ACTIVE));

  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> (hCount == '0 && vCount == '0));

endmodule

bind vid_raster_timer vrt_checker #(
  .H_ACTIVE(H_ACTIVE), .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END), .H_TOTAL(H_TOTAL),
  .V_ACTIVE(V_ACTIVE), .V_SYNC_START(V_SYNC_START), .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL)
) u_vrtChk (.*);

// File: tb/test_vid_raster_timer.sv
module test_vid_raster_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pixEn = 1'b0;
  logic [8:0] hCount;
  logic [9:0] vCount;
  logic       hSyncN, vSyncN, displayEnable, frameEnd;

  int checks = 0;
  int fails = 0;
  int refH = 0;
  int refV = 0;

  always #4 clk = ~clk;

  vid_raster_timer i_vid_raster_timer (
    .clk(clk), .rst(rst), .pixEn(pixEn),
    .hCount(hCount), .vCount(vCount),
    .hSyncN(hSyncN), .vSyncN(vSyncN),
    .displayEnable(displayEnable), .frameEnd(frameEnd)
  );

  function automatic int expHs(int h);
    return (h >= 210 && h < 242) ? 0 : 1;
  endfunction

  function automatic int expVs(int v);
    return (v >= 601 && v < 605) ? 0 : 1;
  endfunction

  function automatic int expDen(int h, int v);
    return (h < 200 && v < 600) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit r);
    int prevH;
    int prevV;
    string hTag;
    string vTag;
    @(negedge clk);
    pixEn = en;
    rst = r;
    #1;
    // R9: end-of-frame pulse follows enable and the last counts
    chk("R9 frameEnd", int'(frameEnd), (!r && en && refH == 263 && refV == 627) ? 1 : 0);
    prevH = refH;
    prevV = refV;
    @(posedge clk);
    if (r) begin
      refH = 0; refV = 0;
    end else if (en) begin
      if (refH == 263) begin
        refH = 0;
        refV = (refV == 627) ? 0 : refV + 1;
      end else begin
        refH = refH + 1;
      end
    end
    #2;
    if (r)              begin hTag = "R1 hCount"; vTag = "R1 vCount"; end
    else if (!en)       begin hTag = "R3 hCount"; vTag = "R3 vCount"; end
    else if (prevH == 263) begin hTag = "R4 hCount"; vTag = (prevV == 627) ? "R5 vCount wrap" : "R5 vCount"; end
    else                begin hTag = "R2 hCount"; vTag = "R5 vCount hold"; end
    chk(hTag, int'(hCount), refH);
    chk(vTag, int'(vCount), refV);
    chk(r ? "R1 hSyncN" : (!en ? "R3 hSyncN" : "R6 hSyncN"), int'(hSyncN), expHs(refH));
    chk(r ? "R1 vSyncN" : (!en ? "R3 vSyncN" : "R7 vSyncN"), int'(vSyncN), expVs(refV));
    chk(r ? "R1 displayEnable" : "R8 displayEnable", int'(displayEnable), expDen(refH, refV));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit held;
    bit wrapped;
    void'($urandom(32'h5eed_0042));
    // R1: reset state with enable high
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    // R2 R3: random gated enable, with a reset in the middle
    for (int i = 0; i < 1200; i++) begin
      step(1'($urandom % 2), (i == 600) ? 1'b1 : 1'b0);
    end
    // R4 R5 R6 R7 R8: continuous enable through one full frame and past the wrap
    held = 1'b0;
    wrapped = 1'b0;
    while (!(wrapped && refV == 1)) begin
      if (refH == 263 && refV == 627 && !held) begin
        // R9: withheld enable at the last pixel gives no pulse
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0);
        held = 1'b1;
      end
      step(1'b1, 1'b0);
      if (refH == 0 && refV == 0) wrapped = 1'b1;
    end
    // R3: a few disabled cycles at the end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule